// File: doc/BRIEF.md
# SPI Frame Transfer Counter

This block keeps a 16-bit tally of the frames a master-mode SPI engine has shifted out, so that software walking a command queue can see how far the engine has got. The engine reports two events to the block: a one-cycle pulse when a frame begins, carrying that frame's clear-count command flag, and a one-cycle pulse when the final bit of a frame leaves the shifter. The count is visible through a 32-bit register view. The tally occupies the upper half of that view and the lower half always reads zero.

Software can preset the tally by writing the register. It must only do so while the engine is stopped. The block enforces this with a running input: a write made while that input is high is dropped. A frame whose command requests a clear zeroes the tally at its start. Each last-bit pulse adds one, and the tally wraps from 65535 back to 0. When events coincide in one cycle, an accepted write has the highest priority. A clear and an increment in the same cycle are merged, so the result is 1. A frame that was cleared at its start therefore ends with a count of 1.

Each cycle the next-value logic picks one of five operations: HOLD, LOAD, CLEAR, INC or CLEAR_INC. It uses a fixed priority order to do this. The counter register then applies the chosen operation at the clock edge.

Top module: `spi_xfer_tally`

## Requirements
- R1: After reset, `rd_data` reads 32'h0000_0000.
- R2: `rd_data[15:0]` is always zero, and `rd_data[31:16]` always shows the current tally.
- R3: A cycle in which `last_bit` is high and no other event happens makes the tally one larger in the following cycle.
- R4: A cycle in which `wr_en` is high and `busy` is low loads `wr_data[31:16]` into the tally in the following cycle. `wr_data[15:0]` is ignored.
- R5: A write made while `busy` is high leaves the tally unchanged.
- R6: A cycle in which both `frame_start` and `frame_clr` are high, with no other event, sets the tally to 0 in the following cycle.
- R7: `frame_start` with `frame_clr` low leaves the tally unchanged. `frame_clr` without `frame_start` also leaves it unchanged.
- R8: An increment from 65535 gives 0.
- R9: A clear at frame start and a last-bit pulse in the same cycle give a tally of 1.
- R10: An accepted write in the same cycle as an increment, or as a clear, loads the written value.
- R11: In a cycle with no event, the tally holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse at the start of a frame |
| frame_clr | input | 1 | Clear-count flag of the starting frame's command |
| last_bit | input | 1 | Pulse as the last bit of a frame is sent |
| busy | input | 1 | SPI engine running; blocks writes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; upper half is the preset value |
| rd_data | output | 32 | Register view: tally in upper half, zeros below |

## Verification
The hardest situations to reach are the coincident ones: clear-plus-increment in one cycle, and a write landing together with an increment or a clear. A frame-driven stream almost never produces them, so the bench drives the event pins directly and places the colliding pulses in a single cycle. The wrap case is reached by presetting 65535 through a write and then pulsing `last_bit` once, instead of counting 65536 frames.

// File: rtl/spi_xfer_tally_pkg.sv
package spi_xfer_tally_pkg;

    typedef enum logic [2:0] {
        OP_HOLD      = 3'd0,
        OP_LOAD      = 3'd1,
        OP_CLEAR     = 3'd2,
        OP_INC       = 3'd3,
        OP_CLEAR_INC = 3'd4
    } tally_op_e;

endpackage

// File: rtl/spi_xfer_tally_arb.sv
module spi_xfer_tally_arb
    import spi_xfer_tally_pkg::*;
(
    input  logic      frame_start,
    input  logic      frame_clr,
    input  logic      last_bit,
    input  logic      busy,
    input  logic      wr_en,
    output tally_op_e op
);

    logic wr_ok;
    logic clr_req;

    assign wr_ok   = wr_en & ~busy;
    assign clr_req = frame_start & frame_clr;

    always_comb begin
        if (wr_ok)
            op = OP_LOAD;
        else if (clr_req && last_bit)
            op = OP_CLEAR_INC;
        else if (clr_req)
            op = OP_CLEAR;
        else if (last_bit)
            op = OP_INC;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/spi_xfer_tally_cnt.sv
module spi_xfer_tally_cnt
    import spi_xfer_tally_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tally_op_e        op,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_nx;

    always_comb begin
        unique case (op)
            OP_HOLD:      count_nx = count;
            OP_LOAD:      count_nx = load_val;
            OP_CLEAR:     count_nx = '0;
            OP_INC:       count_nx = count + ONE;
            OP_CLEAR_INC: count_nx = ONE;
            default:      count_nx = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else
            count <= count_nx;
    end

endmodule

// File: rtl/spi_xfer_tally.sv
module spi_xfer_tally
    import spi_xfer_tally_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             frame_clr,
    input  logic             last_bit,
    input  logic             busy,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);

    localparam int LO_W = REG_W - CNT_W;

    tally_op_e        op;
    logic [CNT_W-1:0] count;

    spi_xfer_tally_arb u_arb (
        .frame_start (frame_start),
        .frame_clr   (frame_clr),
        .last_bit    (last_bit),
        .busy        (busy),
        .wr_en       (wr_en),
        .op          (op)
    );

    spi_xfer_tally_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (wr_data[REG_W-1:LO_W]),
        .count    (count)
    );

    generate
        if (LO_W > 0) begin : g_pad
            assign rd_data = {count, {LO_W{1'b0}}};
        end else begin : g_nopad
            assign rd_data = count;
        end
    endgenerate

endmodule

// File: rtl/spi_xfer_tally_chk.sv
module spi_xfer_tally_chk #(
    parameter int REG_W = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             frame_clr,
    input logic             last_bit,
    input logic             busy,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data
);

    localparam int LO_W = REG_W - CNT_W;

    logic [CNT_W-1:0] tally;
    logic             clr_ev;
    assign tally  = rd_data[REG_W-1:LO_W];
    assign clr_ev = frame_start & frame_clr;

    // R2
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[LO_W-1:0] == '0);

    // R4
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |=> tally == $past(wr_data[REG_W-1:LO_W]));

    // R3
    inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !clr_ev && !(wr_en && !busy)) |=>
            tally == $past(tally) + CNT_W'(1));

    // R9
    clr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && clr_ev && !(wr_en && !busy)) |=> tally == CNT_W'(1));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev && !last_bit && !(wr_en && !busy)) |=> tally == '0);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!last_bit && !clr_ev && !(wr_en && !busy)) |=> $stable(tally));

endmodule

bind spi_xfer_tally spi_xfer_tally_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_clr   (frame_clr),
    .last_bit    (last_bit),
    .busy        (busy),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data)
);

// File: tb/sim_spi_xfer_tally.sv
`timescale 1ns/100ps
module sim_spi_xfer_tally;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        frame_clr = 1'b0;
    logic        last_bit = 1'b0;
    logic        busy = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] model = '0;

    always #2.5 clk = ~clk;

    spi_xfer_tally u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_clr(frame_clr),
        .last_bit(last_bit), .busy(busy), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data)
    );

    task automatic check(string req, logic [31:0] exp);
        n_chk++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    // drive one cycle of events at negedge, model it, sample at next negedge
    task automatic step(logic fs, logic fc, logic lb, logic bs, logic we, logic [31:0] wd);
        frame_start = fs; frame_clr = fc; last_bit = lb;
        busy = bs; wr_en = we; wr_data = wd;
        if (we && !bs)      model = wd[31:16];
        else if (fs && fc)  model = lb ? 16'd1 : 16'd0;
        else if (lb)        model = model + 16'd1;
        @(negedge clk);
        frame_start = 0; frame_clr = 0; last_bit = 0; wr_en = 0; wr_data = '0;
    endtask

    task automatic t_reset();
        check("R1", 32'h0);
    endtask

    task automatic t_increment();
        step(0,0,1,1,0,0); check("R3", {model,16'h0});
        step(1,0,0,1,0,0); step(0,0,1,1,0,0); check("R3", {16'd2,16'h0});
        step(0,0,0,0,0,0); check("R11", {16'd2,16'h0});
    endtask

    task automatic t_preset();
        step(0,0,0,0,1,32'h1234_ABCD); check("R4", 32'h1234_0000);
        check("R2", {model,16'h0});
        step(0,0,0,1,1,32'h5555_FFFF); check("R5", 32'h1234_0000);
    endtask

    task automatic t_clear();
        step(1,1,0,1,0,0); check("R6", 32'h0);
        step(0,0,1,1,0,0); check("R3", 32'h0001_0000);
        step(1,0,0,1,0,0); check("R7", 32'h0001_0000);
        step(0,1,0,1,0,0); check("R7", 32'h0001_0000);
    endtask

    task automatic t_wrap();
        step(0,0,0,0,1,32'hFFFF_0000); check("R4", 32'hFFFF_0000);
        step(0,0,1,1,0,0); check("R8", 32'h0);
    endtask

    task automatic t_collide();
        step(0,0,0,0,1,32'h0040_0000);
        step(1,1,1,1,0,0); check("R9", 32'h0001_0000);
        step(0,0,1,0,1,32'h0077_0000); check("R10", 32'h0077_0000);
        step(1,1,0,0,1,32'h0099_0000); check("R10", 32'h0099_0000);
        step(1,1,1,1,1,32'h0011_0000); check("R5", 32'h0001_0000);
        check("R2", {model,16'h0});
    endtask

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: rd_data=%h expected=done", rd_data);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_increment();
        t_preset();
        t_clear();
        t_wrap();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule